// File: doc/BRIEF.md
# Two-Wire Camera Control Slave

This block lets an external host reach the control registers of a camera over a two-wire serial bus. The host always owns the clock line; the block only ever answers, either taking bytes in or handing a register value back. Both bus lines are brought into a fast system clock domain through synchronisers. Start and stop conditions are found as data-line edges that occur while the clock line is high. The data line is open-drain: the block can pull it low or let it float.

The block holds three registers: a mode word, an exposure value and a gain value. The mode word drives the camera's operating enables. On reset it is loaded from five strap pins, and after that only a bus write can change it. The slave address is seven bits wide. Its upper five bits are a fixed parameter and its lowest two bits come from two strap pins.

Top module: `cam_ctl_slave`

## Requirements
- R1: The slave address is {ADDR_HI, strap_addr1, strap_addr0}, with ADDR_HI = 5'b01011 by default. The address pins are used live. A message whose first byte carries any other address gets no acknowledge and changes nothing.
- R2: Bit 0 of the first byte selects the direction: 0 means the host writes and 1 means the host reads.
- R3: A write of exactly three bytes (address, index, value) commits at the stop condition. It stores the value byte in bits 7:0 of the indexed register and clears the upper bits.
- R4: A write of exactly five bytes (address, index, spare, high, low) commits at the stop condition. The spare byte is dropped, and the register receives the 16-bit value {high, low}.
- R5: A write of any other length changes no register. Once its index byte has been acknowledged, that byte still sets the read pointer. A write ended by a repeated start is not committed.
- R6: A read returns the register at the read pointer: first bits 15:8, then bits 7:0, then 0x00 for any further byte. After the host fails to acknowledge a byte, the block releases the data line.
- R7: Index 0x00 is the mode word: bit 0 linear, bit 1 auto exposure, bit 2 auto gain, bit 3 backlight, bit 4 625-line standard. Index 0x01 is the 16-bit exposure value. Index 0x02 is the 8-bit gain value. Writes to any other index are ignored, and reads of them return 0.
- R8: While reset is low, the mode word follows the strap pins. After reset is released, a change on a strap pin has no effect.
- R9: The mode_auto_gain output is high only when both the stored auto-gain bit and the stored auto-exposure bit are set. A read of the mode word returns the stored auto-gain bit.
- R10: Active-low reset clears exposure and gain to 0 and reloads the mode word from the straps.
- R11: The block acknowledges every accepted byte by pulling the data line low. It never drives the line high. It releases the line on every start and every stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_clk_i | input | 1 | Serial bus clock from the host |
| bus_dat_i | input | 1 | Sensed level of the serial data line |
| bus_dat_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| strap_addr0 | input | 1 | Address bit 0 strap |
| strap_addr1 | input | 1 | Address bit 1 strap |
| strap_linear | input | 1 | Power-up output curve: 1 linear, 0 gamma |
| strap_auto_exp | input | 1 | Power-up auto-exposure enable |
| strap_auto_gain | input | 1 | Power-up auto-gain enable |
| strap_backlight | input | 1 | Power-up backlight exposure mode |
| strap_std625 | input | 1 | Power-up video standard: 1 625-line, 0 525-line |
| mode_linear | output | 1 | Linear output selected |
| mode_auto_exp | output | 1 | Auto exposure enabled |
| mode_auto_gain | output | 1 | Effective auto gain enable |
| mode_backlight | output | 1 | Backlight exposure mode |
| mode_std625 | output | 1 | 625-line standard selected |
| exposure_o | output | EXP_W | Stored exposure value |
| gain_o | output | GAIN_W | Stored gain value |

## Verification
A table of writes covers both message lengths to each mapped index and to one unmapped index. Each write is followed by a read-back, which tells apart truncation to a register's width, the zero-fill of short writes and the dropping of the spare byte. Directed messages then vary the framing: a foreign address, a changed address strap, a four-byte write, an index-only write and a three-byte read. These show that the address comparison, the commit on length and the read pointer work separately from one another. Strap changes before and after reset, together with mode words that set auto gain with and without auto exposure, separate what is stored from what is effective.

// File: rtl/cam_ctl_pkg.sv
`timescale 1ns/1ps
package cam_ctl_pkg;

   // Mode word, bit 0 first in the register view
   typedef struct packed {
      logic std625;
      logic backlight;
      logic auto_gain;
      logic auto_exp;
      logic linear;
   } cam_mode_t;

   localparam int MODE_W = $bits(cam_mode_t);

   localparam logic [7:0] IDX_MODE = 8'h00;
   localparam logic [7:0] IDX_EXPO = 8'h01;
   localparam logic [7:0] IDX_GAIN = 8'h02;

   localparam int FRAME_SHORT = 3;
   localparam int FRAME_LONG  = 5;

   typedef enum logic [2:0] {
      BUS_IDLE,
      BUS_RX,
      BUS_ACK,
      BUS_TX,
      BUS_HACK,
      BUS_TXNEXT
   } bus_state_t;

endpackage

// File: rtl/cam_line_sync.sv
`timescale 1ns/1ps
module cam_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], din};
   end

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/cam_reg_file.sv
`timescale 1ns/1ps
module cam_reg_file
   import cam_ctl_pkg::*;
#(
   parameter int EXP_W   = 16,
   parameter int GAIN_W  = 8,
   parameter int EXP_RST = 0,
   parameter int GAIN_RST = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cam_mode_t         strap_mode,
   input  logic              wr_en,
   input  logic [7:0]        wr_idx,
   input  logic [15:0]       wr_data,
   input  logic [7:0]        rd_idx,
   output cam_mode_t         mode_q,
   output logic              agc_eff,
   output logic [EXP_W-1:0]  expo_q,
   output logic [GAIN_W-1:0] gain_q,
   output logic [15:0]       rd_data
);
   logic [15:0] expo_ext;
   logic [15:0] gain_ext;
   logic [15:0] mode_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= strap_mode;
         expo_q <= EXP_W'(EXP_RST);
         gain_q <= GAIN_W'(GAIN_RST);
      end else if (wr_en) begin
         case (wr_idx)
            IDX_MODE: mode_q <= cam_mode_t'(wr_data[MODE_W-1:0]);
            IDX_EXPO: expo_q <= wr_data[EXP_W-1:0];
            IDX_GAIN: gain_q <= wr_data[GAIN_W-1:0];
            default:  ;
         endcase
      end
   end

   // Gain follows exposure: it cannot act while exposure control is off
   assign agc_eff = mode_q.auto_gain & mode_q.auto_exp;

   generate
      if (EXP_W == 16) begin : g_expo_full
         assign expo_ext = expo_q;
      end else begin : g_expo_pad
         assign expo_ext = {{(16-EXP_W){1'b0}}, expo_q};
      end
      if (GAIN_W == 16) begin : g_gain_full
         assign gain_ext = gain_q;
      end else begin : g_gain_pad
         assign gain_ext = {{(16-GAIN_W){1'b0}}, gain_q};
      end
   endgenerate

   assign mode_ext = {{(16-MODE_W){1'b0}}, mode_q};

   always_comb begin
      case (rd_idx)
         IDX_MODE: rd_data = mode_ext;
         IDX_EXPO: rd_data = expo_ext;
         IDX_GAIN: rd_data = gain_ext;
         default:  rd_data = 16'h0000;
      endcase
   end
endmodule

// File: rtl/cam_bus_engine.sv
`timescale 1ns/1ps
module cam_bus_engine
   import cam_ctl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_s,
   input  logic        sda_s,
   input  logic [6:0]  dev_addr,
   input  logic [15:0] rd_data,
   output logic [7:0]  rd_ptr,
   output logic        wr_en,
   output logic [7:0]  wr_idx,
   output logic [15:0] wr_data,
   output logic        pull,
   output logic        start_det,
   output logic        stop_det
);
   localparam logic [2:0] CNT_SHORT = 3'(FRAME_SHORT);
   localparam logic [2:0] CNT_LONG  = 3'(FRAME_LONG);

   bus_state_t  state;
   logic        scl_q, sda_q;
   logic [3:0]  bit_cnt;
   logic [2:0]  byte_cnt;
   logic [7:0]  shreg;
   logic [7:0]  tx_sh;
   logic [7:0]  d_prev, d_last;
   logic [1:0]  rd_sel;
   logic        is_read;
   logic        scl_rise, scl_fall;
   logic [7:0]  rd_byte;

   assign start_det = scl_s & scl_q &  sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q &  sda_s;
   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;

   always_comb begin
      case (rd_sel)
         2'd0:    rd_byte = rd_data[15:8];
         2'd1:    rd_byte = rd_data[7:0];
         default: rd_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= BUS_IDLE;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         shreg    <= '0;
         tx_sh    <= '0;
         d_prev   <= '0;
         d_last   <= '0;
         rd_sel   <= '0;
         is_read  <= 1'b0;
         rd_ptr   <= '0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
         pull     <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state    <= BUS_RX;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            is_read  <= 1'b0;
            pull     <= 1'b0;
         end else if (stop_det) begin
            state  <= BUS_IDLE;
            pull   <= 1'b0;
            wr_idx <= rd_ptr;
            if (!is_read && byte_cnt == CNT_SHORT) begin
               wr_en   <= 1'b1;
               wr_data <= {8'h00, d_last};
            end else if (!is_read && byte_cnt == CNT_LONG) begin
               wr_en   <= 1'b1;
               wr_data <= {d_prev, d_last};
            end
         end else begin
            case (state)
               BUS_RX: begin
                  if (scl_rise && bit_cnt != 4'd8) begin
                     shreg   <= {shreg[6:0], sda_s};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     bit_cnt <= '0;
                     if (byte_cnt == 3'd0) begin
                        if (shreg[7:1] == dev_addr) begin
                           is_read  <= shreg[0];
                           byte_cnt <= 3'd1;
                           rd_sel   <= '0;
                           pull     <= 1'b1;
                           state    <= BUS_ACK;
                        end else begin
                           state <= BUS_IDLE;
                        end
                     end else begin
                        if (byte_cnt == 3'd1) begin
                           rd_ptr <= shreg;
                        end else begin
                           d_prev <= d_last;
                           d_last <= shreg;
                        end
                        if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
                        pull  <= 1'b1;
                        state <= BUS_ACK;
                     end
                  end
               end
               BUS_ACK, BUS_TXNEXT: begin
                  if (scl_fall) begin
                     if (is_read) begin
                        tx_sh   <= rd_byte;
                        pull    <= ~rd_byte[7];
                        bit_cnt <= '0;
                        if (rd_sel != 2'd2) rd_sel <= rd_sel + 2'd1;
                        state   <= BUS_TX;
                     end else begin
                        pull  <= 1'b0;
                        state <= BUS_RX;
                     end
                  end
               end
               BUS_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == 4'd7) begin
                        pull  <= 1'b0;
                        state <= BUS_HACK;
                     end else begin
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                        pull    <= ~tx_sh[6];
                        bit_cnt <= bit_cnt + 4'd1;
                     end
                  end
               end
               BUS_HACK: begin
                  if (scl_rise) state <= sda_s ? BUS_IDLE : BUS_TXNEXT;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/cam_ctl_slave.sv
`timescale 1ns/1ps
module cam_ctl_slave
   import cam_ctl_pkg::*;
#(
   parameter logic [4:0] ADDR_HI     = 5'b01011,
   parameter int         SYNC_STAGES = 2,
   parameter int         EXP_W       = 16,
   parameter int         GAIN_W      = 8,
   parameter int         EXP_RST     = 0,
   parameter int         GAIN_RST    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_clk_i,
   input  logic              bus_dat_i,
   output logic              bus_dat_pull_o,
   input  logic              strap_addr0,
   input  logic              strap_addr1,
   input  logic              strap_linear,
   input  logic              strap_auto_exp,
   input  logic              strap_auto_gain,
   input  logic              strap_backlight,
   input  logic              strap_std625,
   output logic              mode_linear,
   output logic              mode_auto_exp,
   output logic              mode_auto_gain,
   output logic              mode_backlight,
   output logic              mode_std625,
   output logic [EXP_W-1:0]  exposure_o,
   output logic [GAIN_W-1:0] gain_o
);
   localparam int N_LINES = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (EXP_W < 1 || EXP_W > 16) begin : g_bad_exp
         $error("EXP_W must lie in 1..16");
      end
      if (GAIN_W < 1 || GAIN_W > 16) begin : g_bad_gain
         $error("GAIN_W must lie in 1..16");
      end
   endgenerate

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] sync_lines;
   cam_mode_t   strap_vec;
   cam_mode_t   mode_q;
   logic        agc_eff;
   logic [6:0]  dev_addr;
   logic [7:0]  rd_ptr;
   logic [15:0] rd_data;
   logic        wr_en;
   logic [7:0]  wr_idx;
   logic [15:0] wr_data;
   logic        bus_start, bus_stop;

   assign raw_lines = {bus_dat_i, bus_clk_i};

   for (genvar g = 0; g < N_LINES; g++) begin : g_sync
      cam_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw_lines[g]),
         .dout (sync_lines[g])
      );
   end

   assign dev_addr  = {ADDR_HI, strap_addr1, strap_addr0};
   assign strap_vec = '{std625:    strap_std625,
                        backlight: strap_backlight,
                        auto_gain: strap_auto_gain,
                        auto_exp:  strap_auto_exp,
                        linear:    strap_linear};

   cam_bus_engine u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (sync_lines[0]),
      .sda_s    (sync_lines[1]),
      .dev_addr (dev_addr),
      .rd_data  (rd_data),
      .rd_ptr   (rd_ptr),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .pull     (bus_dat_pull_o),
      .start_det(bus_start),
      .stop_det (bus_stop)
   );

   cam_reg_file #(
      .EXP_W   (EXP_W),
      .GAIN_W  (GAIN_W),
      .EXP_RST (EXP_RST),
      .GAIN_RST(GAIN_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_mode(strap_vec),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (rd_ptr),
      .mode_q    (mode_q),
      .agc_eff   (agc_eff),
      .expo_q    (exposure_o),
      .gain_q    (gain_o),
      .rd_data   (rd_data)
   );

   assign mode_linear    = mode_q.linear;
   assign mode_auto_exp  = mode_q.auto_exp;
   assign mode_auto_gain = agc_eff;
   assign mode_backlight = mode_q.backlight;
   assign mode_std625    = mode_q.std625;
endmodule

// File: rtl/cam_ctl_checker.sv
`timescale 1ns/1ps
module cam_ctl_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [4:0] strap_vec,
   input logic [4:0] mode_vec,
   input logic       wr_en,
   input logic       bus_start,
   input logic       bus_stop,
   input logic       pull
);
   AST_MODE_FROM_STRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> mode_vec == $past(strap_vec)); // R8

   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mode_vec)); // R8

   AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(bus_stop)); // R5

   AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R5

   AST_RELEASE_START: assert property (@(posedge clk) disable iff (!rst_n)
      bus_start |=> !pull); // R11

   AST_RELEASE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> !pull); // R11
endmodule

bind cam_ctl_slave cam_ctl_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .strap_vec(strap_vec),
   .mode_vec (mode_q),
   .wr_en    (wr_en),
   .bus_start(bus_start),
   .bus_stop (bus_stop),
   .pull     (bus_dat_pull_o)
);

// File: tb/cam_ctl_slave_tb.sv
`timescale 1ns/1ps
module cam_ctl_slave_tb;
   localparam int HALF = 12;
   localparam logic [4:0] AHI = 5'b01011;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_h = 1'b1, sda_h = 1'b1;
   logic pull;
   logic sda_line;
   logic a0 = 1'b0, a1 = 1'b0;
   logic s_lin = 1'b0, s_aec = 1'b1, s_agc = 1'b1, s_bk = 1'b0, s_std = 1'b1;
   logic m_lin, m_aec, m_agc, m_bk, m_std;
   logic [15:0] expo;
   logic [7:0]  gain;

   int n_checks = 0;
   int n_err    = 0;
   bit done     = 1'b0;

   assign sda_line = sda_h & ~pull;

   cam_ctl_slave u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_clk_i(scl_h), .bus_dat_i(sda_line), .bus_dat_pull_o(pull),
      .strap_addr0(a0), .strap_addr1(a1),
      .strap_linear(s_lin), .strap_auto_exp(s_aec), .strap_auto_gain(s_agc),
      .strap_backlight(s_bk), .strap_std625(s_std),
      .mode_linear(m_lin), .mode_auto_exp(m_aec), .mode_auto_gain(m_agc),
      .mode_backlight(m_bk), .mode_std625(m_std),
      .exposure_o(expo), .gain_o(gain)
   );

   // {index, long frame, value sent, expected read-back}
   localparam logic [40:0] VEC [0:7] = '{
      {8'h01, 1'b1, 16'hA55A, 16'hA55A},   // R4 full exposure
      {8'h01, 1'b0, 16'h0137, 16'h0037},   // R3 short write clears high byte
      {8'h02, 1'b1, 16'h1234, 16'h0034},   // R7 gain keeps 8 bits
      {8'h02, 1'b0, 16'h00C3, 16'h00C3},   // R3 gain short
      {8'h00, 1'b0, 16'h0009, 16'h0009},   // R7 mode linear+backlight
      {8'h00, 1'b1, 16'hFFFF, 16'h001F},   // R7 mode keeps 5 bits
      {8'h05, 1'b0, 16'h00AA, 16'h0000},   // R7 unmapped index
      {8'h01, 1'b1, 16'h0000, 16'h0000}    // R4 exposure back to zero
   };

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bit_io(input logic b, output logic r);
      sda_h = b;
      wclk(HALF);
      scl_h = 1'b1;
      wclk(HALF/2);
      r = sda_line;
      wclk(HALF/2);
      scl_h = 1'b0;
      wclk(2);
   endtask

   task automatic bus_start();
      sda_h = 1'b1; wclk(HALF);
      scl_h = 1'b1; wclk(HALF);
      sda_h = 1'b0; wclk(HALF);
      scl_h = 1'b0; wclk(2);
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; wclk(HALF);
      scl_h = 1'b1; wclk(HALF);
      sda_h = 1'b1; wclk(HALF);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic d;
      for (int i = 7; i >= 0; i--) bit_io(v[i], d);
      bit_io(1'b1, d);
      ack = ~d;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] v);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_io(1'b1, r);
         v[i] = r;
      end
      bit_io(~give_ack, r);
   endtask

   function automatic logic [7:0] dev(input logic rw);
      return {AHI, a1, a0, rw};
   endfunction

   task automatic wr_frame(input logic [7:0] first, input logic [31:0] rest,
                           input int nrest, output logic aack);
      logic k_ack;
      bus_start();
      send_byte(first, aack);
      if (aack)
         for (int k = 0; k < nrest; k++) send_byte(rest[31-8*k -: 8], k_ack);
      bus_stop();
   endtask

   task automatic rd_cur(output logic [15:0] v, output logic aack);
      logic [7:0] hi, lo;
      bus_start();
      send_byte(dev(1'b1), aack);
      recv_byte(1'b1, hi);
      recv_byte(1'b0, lo);
      bus_stop();
      v = {hi, lo};
   endtask

   task automatic rd_reg(input logic [7:0] idx, output logic [15:0] v);
      logic a;
      wr_frame(dev(1'b0), {idx, 24'h0}, 1, a);
      rd_cur(v, a);
   endtask

   function automatic logic [4:0] modes();
      return {m_std, m_bk, m_agc, m_aec, m_lin};
   endfunction

   initial begin
      logic [15:0] rv;
      logic        ack;
      logic [7:0]  b0, b1, b2;

      wclk(10);
      rst_n = 1'b1;
      wclk(5);

      // reset state
      chk("R8 mode ports follow straps", modes(), 5'b10110);
      chk("R10 exposure at reset", expo, 16'h0);
      chk("R10 gain at reset", gain, 8'h0);
      chk("R11 line released when idle", pull, 1'b0);
      rd_reg(8'h00, rv);
      chk("R2 R6 R7 mode word read", rv, 16'h0016);

      // straps moving after reset do nothing
      s_lin = 1'b1; s_aec = 1'b0;
      wclk(10);
      chk("R8 strap change ignored", modes(), 5'b10110);

      // table walk
      for (int k = 0; k < 8; k++) begin
         logic [40:0] v;
         v = VEC[k];
         if (v[32])
            wr_frame(dev(1'b0), {v[40:33], 8'hEE, v[31:16]}, 4, ack);
         else
            wr_frame(dev(1'b0), {v[40:33], v[23:16], 16'h0}, 2, ack);
         chk("R1 write addressed", ack, 1'b1);
         rd_reg(v[40:33], rv);
         chk("R3 R4 R7 table read-back", rv, v[15:0]);
      end
      chk("R7 mode ports after table", modes(), 5'b11111);
      chk("R7 gain port after table", gain, 8'hC3);

      wr_frame(dev(1'b0), {8'h01, 8'hEE, 16'hBEEF}, 4, ack);
      chk("R4 exposure port", expo, 16'hBEEF);

      // foreign address
      wr_frame({AHI, 2'b01, 1'b0}, {8'h01, 8'h11, 16'h0}, 2, ack);
      chk("R1 foreign address not acked", ack, 1'b0);
      chk("R1 foreign write dropped", expo, 16'hBEEF);

      // address strap moved
      a0 = 1'b1;
      wclk(5);
      wr_frame(dev(1'b0), {8'h01, 8'h22, 16'h0}, 2, ack);
      chk("R1 new strap address acked", ack, 1'b1);
      chk("R3 short write via new address", expo, 16'h0022);
      wr_frame({AHI, 2'b00, 1'b0}, {8'h01, 8'h33, 16'h0}, 2, ack);
      chk("R1 old address no longer acked", ack, 1'b0);
      a0 = 1'b0;
      wclk(5);

      // four-byte write
      wr_frame(dev(1'b0), {8'h01, 8'hEE, 8'h12, 8'h34}, 3, ack);
      chk("R5 four-byte write dropped", expo, 16'h0022);
      rd_cur(rv, ack);
      chk("R5 pointer set by dropped write", rv, 16'h0022);

      // index-only message
      wr_frame(dev(1'b0), {8'h02, 24'h0}, 1, ack);
      chk("R5 index-only leaves gain", gain, 8'hC3);
      rd_cur(rv, ack);
      chk("R5 R6 read via index-only pointer", rv, 16'h00C3);

      // auto gain dependency
      wr_frame(dev(1'b0), {8'h00, 8'h04, 16'h0}, 2, ack);
      chk("R9 gain without exposure disabled", {m_agc, m_aec}, 2'b00);
      rd_reg(8'h00, rv);
      chk("R9 stored gain bit readable", rv, 16'h0004);
      wr_frame(dev(1'b0), {8'h00, 8'h06, 16'h0}, 2, ack);
      chk("R9 gain with exposure enabled", {m_agc, m_aec}, 2'b11);

      // three-byte read, release after NACK
      bus_start();
      send_byte(dev(1'b1), ack);
      chk("R2 read address acked", ack, 1'b1);
      recv_byte(1'b1, b0);
      recv_byte(1'b1, b1);
      recv_byte(1'b0, b2);
      wclk(6);
      chk("R6 R11 released after NACK", pull, 1'b0);
      bus_stop();
      chk("R6 first byte high", b0, 8'h00);
      chk("R6 second byte low", b1, 8'h06);
      chk("R6 extra byte zero", b2, 8'h00);

      // reset in mid-run
      @(negedge clk) rst_n = 1'b0;
      wclk(3);
      rst_n = 1'b1;
      wclk(3);
      chk("R10 exposure cleared", expo, 16'h0);
      chk("R10 gain cleared", gain, 8'h0);
      chk("R10 R9 mode reloaded from straps", modes(), 5'b10001);
      rd_reg(8'h00, rv);
      chk("R10 mode word reloaded", rv, 16'h0015);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      wclk(190000);
      if (!done) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end
endmodule